// File: doc/BRIEF.md
# Receiver Margining Sweep Sequencer

This block runs one margining sweep, in time or in voltage, against a single receiver on behalf of the host. It first programs an error limit into the receiver. It then issues step commands with a growing offset. After each step it reads the receiver's two-bit status, waits out a setup phase and then a dwell period counted in 1 ms ticks. The sweep stops at the first failing offset or when the configured maximum step count is reached.

When the sweep ends, the block writes a fixed four-command restore sequence and pulses `done`. It also presents the largest offset that passed, with flags for a sweep that ran to the configured limit and for a receiver that stopped answering. Writes toward the control register are single-cycle strobes with no reply. Each read is answered by one `reg_rvalid` pulse that carries a step-valid bit and the status code.

Top module: `margin_sweep_seq`

## Requirements
- R1: A `start` pulse in idle samples the configuration and writes an error-limit command (code 001, payload = `err_limit` zero-extended). The next write is the step command for offset 1.
- R2: The command word is {code[2:0], payload[7:0]}. A step command uses code 010 for timing and 011 for voltage, with payload {dir_neg, 7-bit offset}. Between two passes a no-command word (code 000, payload 0) is written, and the offset grows by exactly one per pass.
- R3: The read data is {step_valid, status[1:0]}. Status 00 (too many errors), or status 11 with step_valid = 1, ends the sweep as a failure at the current offset.
- R4: Status 01, or status 11 with step_valid = 0, means setup: the block waits for the next 1 ms tick and reads again. If the reply on the read taken at SETUP_MS (default 200) ticks after the step is still setup, the sweep fails.
- R5: Once status 10 is seen, the block re-reads on every tick. A reply of 10 once `dwell_ms` ticks have elapsed (immediately when `dwell_ms` is 0) makes the offset pass. Any other reply during the dwell fails the sweep.
- R6: On failure `res_margin` is the current offset minus one, so a failure at offset 1 reports 0, and `res_full` is 0.
- R7: When offset `max_steps` passes, `res_margin` equals `max_steps` and `res_full` is 1.
- R8: When no reply arrives within `rsp_timeout` cycles after a read, the sweep fails at the current offset with `res_noresp` = 1.
- R9: Every sweep ends with the writes go-to-normal (100), no-command, clear-error-log (101), no-command, all with payload 0. `done` is high for the single cycle after the last of them, and the block is then idle.
- R10: During and after reset, `reg_wr`, `reg_rd`, `done` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| start | input | 1 | Begin a sweep (accepted in idle only) |
| axis_volt | input | 1 | 0 = timing offset, 1 = voltage offset |
| dir_neg | input | 1 | Offset direction placed in the step payload |
| max_steps | input | STEP_W | Largest offset to try (at least 1) |
| dwell_ms | input | DWELL_W | Dwell ticks per offset |
| err_limit | input | LIM_W | Error limit programmed before the sweep |
| rsp_timeout | input | TO_W | Cycles allowed for a read reply |
| reg_wr | output | 1 | Command write strobe |
| reg_rd | output | 1 | Status read strobe |
| reg_wdata | output | 11 | Command word {code, payload} |
| reg_rvalid | input | 1 | Read reply strobe |
| reg_rdata | input | 3 | Reply {step_valid, status} |
| done | output | 1 | Sweep finished, one cycle |
| res_margin | output | STEP_W | Largest passing offset |
| res_full | output | 1 | Sweep reached `max_steps` without failing |
| res_noresp | output | 1 | Sweep ended on a missing reply |

## Verification
The assertions assume that the configuration inputs stay steady for the whole sweep, that `max_steps` is at least 1, and that a reply never arrives in the same cycle as its read strobe, nor when no read is pending. The bench keeps to these assumptions. Its receiver model answers each read exactly two cycles later, or not at all for the offset chosen to go silent. The model changes its configuration only between sweeps and never uses a zero step limit.

// File: rtl/msweep_pkg.sv
// Shared encodings for the margining sweep sequencer.
// Assumes an 11-bit command word {code, payload} and a 3-bit reply.
package msweep_pkg;
    localparam int CODE_W = 3;
    localparam int PAY_W  = 8;
    localparam int WORD_W = CODE_W + PAY_W;
    localparam int RSP_W  = 3;

    typedef enum logic [CODE_W-1:0] {
        CMD_NOP    = 3'b000,
        CMD_ERRLIM = 3'b001,
        CMD_STEP_T = 3'b010,
        CMD_STEP_V = 3'b011,
        CMD_NORMAL = 3'b100,
        CMD_CLRLOG = 3'b101
    } cmd_e;

    typedef enum logic [1:0] {
        STS_TOOMANY = 2'b00,
        STS_SETUP   = 2'b01,
        STS_RUN     = 2'b10,
        STS_NAK     = 2'b11
    } status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_LIM,
        S_WR_STEP,
        S_RD,
        S_WAIT_RSP,
        S_WAIT_TICK,
        S_WR_NOP,
        S_CLEAN
    } seq_st_e;
endpackage

// File: rtl/msweep_cmd_fmt.sv
// Builds the command word written to the receiver control register.
// Assumes STEP_W <= 7 and LIM_W <= 8 so the fields fit the payload.
module msweep_cmd_fmt
    import msweep_pkg::*;
#(
    parameter int STEP_W = 6,
    parameter int LIM_W  = 6
) (
    input  cmd_e                kind,
    input  logic                dir_neg,
    input  logic [STEP_W-1:0]   step,
    input  logic [LIM_W-1:0]    err_limit,
    output logic [WORD_W-1:0]   word
);
    logic [PAY_W-1:0] payload;

    // Select the payload that belongs to the command kind.
    always_comb begin
        payload = '0;
        case (kind)
            CMD_STEP_T, CMD_STEP_V: payload = {dir_neg, 7'(step)};
            CMD_ERRLIM:             payload = 8'(err_limit);
            default:                payload = '0;
        endcase
        word = {kind, payload};
    end
endmodule

// File: rtl/msweep_status_dec.sv
// Classifies a reply {step_valid, status} into fail, setup-like or running.
// Assumes the reply is only looked at while a read is pending.
module msweep_status_dec
    import msweep_pkg::*;
(
    input  logic [RSP_W-1:0] rdata,
    output logic             is_fail,
    output logic             is_setup,
    output logic             is_run
);
    status_e sts;
    logic    step_ok;

    // Decode the status code, splitting the NAK case on the step-valid bit.
    always_comb begin
        sts      = status_e'(rdata[1:0]);
        step_ok  = rdata[2];
        is_fail  = (sts == STS_TOOMANY) || (sts == STS_NAK && step_ok);
        is_setup = (sts == STS_SETUP)   || (sts == STS_NAK && !step_ok);
        is_run   = (sts == STS_RUN);
    end
endmodule

// File: rtl/msweep_rsp_timer.sv
// Counts cycles while a reply is awaited and flags when the limit is reached.
// Assumes clear is raised in the read cycle that precedes each wait.
module msweep_rsp_timer #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    assign expired = (cnt >= limit);

    // Advance the wait counter, holding once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (clear)            cnt <= '0;
        else if (run && !expired)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/margin_sweep_seq.sv
// Margining sweep sequencer: programs an error limit, steps the offset,
// polls status through setup and dwell, then restores the receiver.
// Assumes configuration is steady during a sweep and max_steps >= 1.
module margin_sweep_seq
    import msweep_pkg::*;
#(
    parameter int STEP_W   = 6,
    parameter int DWELL_W  = 8,
    parameter int LIM_W    = 6,
    parameter int TO_W     = 8,
    parameter int SETUP_MS = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_1ms,
    input  logic                start,
    input  logic                axis_volt,
    input  logic                dir_neg,
    input  logic [STEP_W-1:0]   max_steps,
    input  logic [DWELL_W-1:0]  dwell_ms,
    input  logic [LIM_W-1:0]    err_limit,
    input  logic [TO_W-1:0]     rsp_timeout,
    output logic                reg_wr,
    output logic                reg_rd,
    output logic [10:0]         reg_wdata,
    input  logic                reg_rvalid,
    input  logic [2:0]          reg_rdata,
    output logic                done,
    output logic [STEP_W-1:0]   res_margin,
    output logic                res_full,
    output logic                res_noresp
);
    localparam int DWELL_MAX = (1 << DWELL_W) - 1;
    localparam int MS_TOP    = (SETUP_MS > DWELL_MAX) ? SETUP_MS : DWELL_MAX;
    localparam int MS_W      = $clog2(MS_TOP + 2);

    seq_st_e              state;
    logic [STEP_W-1:0]    step_q, max_q;
    logic [DWELL_W-1:0]   dwell_q;
    logic [LIM_W-1:0]     lim_q;
    logic [TO_W-1:0]      tmo_q;
    logic                 axis_q, dir_q;
    logic                 in_dwell;
    logic [MS_W-1:0]      ms_cnt, run_cnt, dwell_ext;
    logic [1:0]           clean_idx;
    cmd_e                 kind;
    logic                 is_fail, is_setup, is_run, expired;

    // Pick the command for the current write state.
    always_comb begin
        kind = CMD_NOP;
        case (state)
            S_WR_LIM:  kind = CMD_ERRLIM;
            S_WR_STEP: kind = axis_q ? CMD_STEP_V : CMD_STEP_T;
            S_CLEAN: begin
                case (clean_idx)
                    2'd0:    kind = CMD_NORMAL;
                    2'd2:    kind = CMD_CLRLOG;
                    default: kind = CMD_NOP;
                endcase
            end
            default:   kind = CMD_NOP;
        endcase
    end

    // Strobes and dwell comparison operands.
    assign reg_wr    = (state == S_WR_LIM) || (state == S_WR_STEP) ||
                       (state == S_WR_NOP) || (state == S_CLEAN);
    assign reg_rd    = (state == S_RD);
    assign dwell_ext = MS_W'(dwell_q);
    assign run_cnt   = in_dwell ? ms_cnt : '0;

    msweep_cmd_fmt #(.STEP_W(STEP_W), .LIM_W(LIM_W)) fmt_i (
        .kind(kind), .dir_neg(dir_q), .step(step_q),
        .err_limit(lim_q), .word(reg_wdata)
    );

    msweep_status_dec dec_i (
        .rdata(reg_rdata), .is_fail(is_fail),
        .is_setup(is_setup), .is_run(is_run)
    );

    msweep_rsp_timer #(.TO_W(TO_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .clear(state == S_RD),
        .run(state == S_WAIT_RSP), .limit(tmo_q), .expired(expired)
    );

    // Sweep state machine, counters and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            step_q     <= '0;
            max_q      <= '0;
            dwell_q    <= '0;
            lim_q      <= '0;
            tmo_q      <= '0;
            axis_q     <= 1'b0;
            dir_q      <= 1'b0;
            in_dwell   <= 1'b0;
            ms_cnt     <= '0;
            clean_idx  <= '0;
            done       <= 1'b0;
            res_margin <= '0;
            res_full   <= 1'b0;
            res_noresp <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        axis_q  <= axis_volt;
                        dir_q   <= dir_neg;
                        max_q   <= max_steps;
                        dwell_q <= dwell_ms;
                        lim_q   <= err_limit;
                        tmo_q   <= rsp_timeout;
                        step_q  <= STEP_W'(1);
                        state   <= S_WR_LIM;
                    end
                end
                S_WR_LIM: state <= S_WR_STEP;
                S_WR_STEP: begin
                    in_dwell <= 1'b0;
                    ms_cnt   <= '0;
                    state    <= S_RD;
                end
                S_RD: state <= S_WAIT_RSP;
                S_WAIT_RSP: begin
                    if (reg_rvalid) begin
                        if (is_fail || (!is_run && in_dwell) ||
                            (is_setup && ms_cnt >= MS_W'(SETUP_MS))) begin
                            res_margin <= step_q - 1'b1;
                            res_full   <= 1'b0;
                            res_noresp <= 1'b0;
                            clean_idx  <= '0;
                            state      <= S_CLEAN;
                        end else if (is_run && run_cnt >= dwell_ext) begin
                            if (step_q >= max_q) begin
                                res_margin <= step_q;
                                res_full   <= 1'b1;
                                res_noresp <= 1'b0;
                                clean_idx  <= '0;
                                state      <= S_CLEAN;
                            end else begin
                                state <= S_WR_NOP;
                            end
                        end else begin
                            if (is_run && !in_dwell) begin
                                in_dwell <= 1'b1;
                                ms_cnt   <= '0;
                            end
                            state <= S_WAIT_TICK;
                        end
                    end else if (expired) begin
                        res_margin <= step_q - 1'b1;
                        res_full   <= 1'b0;
                        res_noresp <= 1'b1;
                        clean_idx  <= '0;
                        state      <= S_CLEAN;
                    end
                end
                S_WAIT_TICK: begin
                    if (tick_1ms) begin
                        ms_cnt <= ms_cnt + 1'b1;
                        state  <= S_RD;
                    end
                end
                S_WR_NOP: begin
                    step_q <= step_q + 1'b1;
                    state  <= S_WR_STEP;
                end
                S_CLEAN: begin
                    clean_idx <= clean_idx + 1'b1;
                    if (clean_idx == 2'd3) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msweep_chk.sv
// Property checker for the margining sweep sequencer, bound to its top.
// Assumes max_steps is steady during a sweep and at least 1.
module msweep_chk
    import msweep_pkg::*;
#(
    parameter int STEP_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STEP_W-1:0] max_steps,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [10:0]       reg_wdata,
    input logic              done,
    input logic [STEP_W-1:0] res_margin,
    input logic              res_full,
    input logic              res_noresp
);
    AST_FIRST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[10:8] == CMD_ERRLIM) |=>
        (reg_wr && reg_wdata[10:9] == 2'b01 && reg_wdata[6:0] == 7'd1)); // R1

    AST_RD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd); // R4

    AST_MARGIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_margin <= max_steps)); // R6

    AST_FULL_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_full) |-> (res_margin == max_steps)); // R7

    AST_NORESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(res_full && res_noresp)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(reg_wr) && $past(reg_wdata) == 11'd0)); // R9
endmodule

bind margin_sweep_seq msweep_chk #(.STEP_W(STEP_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .max_steps(max_steps),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .done(done), .res_margin(res_margin), .res_full(res_full),
    .res_noresp(res_noresp)
);

// File: tb/margin_sweep_seq_tb_top.sv
// Scoreboard bench: the driver queues expected writes and results, the
// monitors compare them as the sequencer produces them.
module margin_sweep_seq_tb_top;
    localparam int STEP_W   = 6;
    localparam int DWELL_W  = 8;
    localparam int LIM_W    = 6;
    localparam int TO_W     = 8;
    localparam int SETUP_MS = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1ms = 1'b0;
    logic start = 1'b0;
    logic axis_volt = 1'b0;
    logic dir_neg = 1'b0;
    logic [STEP_W-1:0]  max_steps = '0;
    logic [DWELL_W-1:0] dwell_ms = '0;
    logic [LIM_W-1:0]   err_limit = '0;
    logic [TO_W-1:0]    rsp_timeout = 8'd20;
    logic reg_wr, reg_rd, done, res_full, res_noresp;
    logic [10:0] reg_wdata;
    logic reg_rvalid = 1'b0;
    logic [2:0] reg_rdata = 3'b000;
    logic [STEP_W-1:0] res_margin;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_total = 0;

    // receiver model knobs, written by the driver between sweeps
    int  m_fail_step = 0;
    logic [2:0] m_fail_code = 3'b000;
    int  m_setup_n = 0;
    bit  m_setup_nak = 1'b0;
    int  m_mute_step = 0;
    int  cur_step = 0;
    int  step_id = 0;

    typedef struct {
        logic [STEP_W-1:0] margin;
        logic full;
        logic noresp;
        string tag;
    } res_t;

    logic [10:0] exp_wr[$];
    string       exp_wr_tag[$];
    res_t        exp_res[$];

    margin_sweep_seq #(
        .STEP_W(STEP_W), .DWELL_W(DWELL_W), .LIM_W(LIM_W),
        .TO_W(TO_W), .SETUP_MS(SETUP_MS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .start(start),
        .axis_volt(axis_volt), .dir_neg(dir_neg), .max_steps(max_steps),
        .dwell_ms(dwell_ms), .err_limit(err_limit), .rsp_timeout(rsp_timeout),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata), .done(done),
        .res_margin(res_margin), .res_full(res_full), .res_noresp(res_noresp)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // 1 ms tick every 10 cycles
    initial begin
        forever begin
            repeat (9) @(negedge clk);
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
        end
    end

    // Write monitor: compares each command word, tracks step writes and reads.
    always @(negedge clk) begin
        if (rst_n && reg_rd) rd_total <= rd_total + 1;
        if (rst_n && reg_wr) begin
            if (reg_wdata[10:9] == 2'b01) begin
                cur_step <= int'(reg_wdata[5:0]);
                step_id  <= step_id + 1;
            end
            if (exp_wr.size() == 0) begin
                check(1'b0, "R2", "unexpected write word", int'(reg_wdata), -1);
            end else begin
                automatic logic [10:0] e = exp_wr.pop_front();
                automatic string t = exp_wr_tag.pop_front();
                check(reg_wdata == e, t, "write word", int'(reg_wdata), int'(e));
            end
        end
    end

    // Result monitor: compares results on done and checks the pulse width.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_res.size() == 0) begin
                check(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
                automatic res_t e = exp_res.pop_front();
                check(res_margin == e.margin, e.tag, "margin", int'(res_margin), int'(e.margin));
                check(res_full == e.full, e.tag, "full flag", int'(res_full), int'(e.full));
                check(res_noresp == e.noresp, e.tag, "noresp flag", int'(res_noresp), int'(e.noresp));
            end
            @(negedge clk);
            check(done == 1'b0, "R9", "done width", int'(done), 0);
        end
    end

    // Receiver model: answers each read two cycles after the strobe.
    initial begin
        automatic int nread = 0;
        automatic int last_id = 0;
        forever begin
            @(negedge clk);
            if (rst_n && reg_rd) begin
                automatic logic [2:0] code;
                automatic bit mute;
                if (step_id != last_id) begin
                    nread = 0;
                    last_id = step_id;
                end
                mute = (cur_step == m_mute_step);
                if (nread < m_setup_n)
                    code = m_setup_nak ? 3'b011 : 3'b001;
                else if (cur_step == m_fail_step && nread >= m_setup_n + 1)
                    code = m_fail_code;
                else
                    code = 3'b010;
                nread++;
                if (!mute) begin
                    @(negedge clk);
                    reg_rvalid = 1'b1;
                    reg_rdata  = code;
                    @(negedge clk);
                    reg_rvalid = 1'b0;
                    reg_rdata  = 3'b000;
                end
            end
        end
    end

    function automatic logic [10:0] word(input logic [2:0] c, input logic [7:0] p);
        return {c, p};
    endfunction

    // Driver: queues expectations for one sweep, starts it and waits for done.
    task automatic run_case(input bit ax, input bit dn, input int mx, input int dw,
                            input int lim, input int fstep, input logic [2:0] fcode,
                            input int sn, input bit snak, input int mstep,
                            input string tag);
        automatic bit setup_fail = (sn > SETUP_MS);
        automatic int exp_reads = 0;
        automatic int rd0;
        automatic res_t r;
        automatic int wait_cyc = 0;
        m_fail_step = fstep; m_fail_code = fcode; m_setup_n = sn;
        m_setup_nak = snak; m_mute_step = mstep;
        exp_wr.push_back(word(3'b001, 8'(lim))); exp_wr_tag.push_back("R1");
        r.tag = tag; r.noresp = 1'b0; r.full = 1'b0; r.margin = '0;
        for (int k = 1; k <= mx; k++) begin
            exp_wr.push_back(word(ax ? 3'b011 : 3'b010, {dn, 7'(k)}));
            exp_wr_tag.push_back(k == 1 ? "R1" : "R2");
            if (k == mstep) begin
                exp_reads += 1; r.margin = STEP_W'(k - 1); r.noresp = 1'b1; break;
            end else if (setup_fail) begin
                exp_reads += SETUP_MS + 1; r.margin = STEP_W'(k - 1); break;
            end else if (k == fstep) begin
                exp_reads += sn + 2; r.margin = STEP_W'(k - 1); break;
            end
            exp_reads += sn + dw + 1;
            if (k == mx) begin
                r.margin = STEP_W'(mx); r.full = 1'b1;
            end else begin
                exp_wr.push_back(11'd0); exp_wr_tag.push_back("R2");
            end
        end
        exp_wr.push_back(word(3'b100, 8'd0)); exp_wr_tag.push_back("R9");
        exp_wr.push_back(11'd0);              exp_wr_tag.push_back("R9");
        exp_wr.push_back(word(3'b101, 8'd0)); exp_wr_tag.push_back("R9");
        exp_wr.push_back(11'd0);              exp_wr_tag.push_back("R9");
        exp_res.push_back(r);
        @(negedge clk);
        axis_volt = ax; dir_neg = dn; max_steps = STEP_W'(mx);
        dwell_ms = DWELL_W'(dw); err_limit = LIM_W'(lim);
        rd0 = rd_total;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        check(done == 1'b1, tag, "sweep finished", int'(done), 1);
        repeat (3) @(negedge clk);
        check(rd_total - rd0 == exp_reads, tag, "read count", rd_total - rd0, exp_reads);
        check(exp_wr.size() == 0, "R9", "writes left", exp_wr.size(), 0);
        check(exp_res.size() == 0, tag, "results left", exp_res.size(), 0);
        exp_wr.delete(); exp_wr_tag.delete(); exp_res.delete();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(reg_wr == 1'b0, "R10", "reg_wr in reset", int'(reg_wr), 0);
        check(reg_rd == 1'b0, "R10", "reg_rd in reset", int'(reg_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R10", "done after reset", int'(done), 0);
        check(res_margin == '0, "R10", "margin after reset", int'(res_margin), 0);
        check(res_full == 1'b0, "R10", "full after reset", int'(res_full), 0);
        check(res_noresp == 1'b0, "R10", "noresp after reset", int'(res_noresp), 0);
        check(reg_wr == 1'b0 && reg_rd == 1'b0, "R10", "idle strobes", int'(reg_wr), 0);

        // R3 R6: too-many-errors during the dwell of offset 3, timing axis
        run_case(1'b0, 1'b0, 5, 3, 10, 3, 3'b000, 2, 1'b0, 0, "R3 R6");
        // R7: voltage axis, negative direction, runs to the limit
        run_case(1'b1, 1'b1, 4, 1, 63, 0, 3'b000, 0, 1'b0, 0, "R7");
        // R3 R6: NAK with valid step count at offset 1 reports zero margin
        run_case(1'b0, 1'b1, 6, 2, 1, 1, 3'b111, 1, 1'b0, 0, "R3 R6");
        // R4: NAK without a valid step count behaves as setup
        run_case(1'b1, 1'b0, 2, 1, 5, 0, 3'b000, 3, 1'b1, 0, "R4");
        // R4: setup for exactly SETUP_MS reads still passes
        run_case(1'b0, 1'b0, 1, 1, 7, 0, 3'b000, SETUP_MS, 1'b0, 0, "R4 R7");
        // R4: still setup on the read at SETUP_MS fails at offset 1
        run_case(1'b0, 1'b0, 3, 1, 7, 0, 3'b000, SETUP_MS + 1, 1'b0, 0, "R4 R6");
        // R8: receiver stops answering at offset 2
        run_case(1'b1, 1'b1, 5, 2, 9, 0, 3'b000, 0, 1'b0, 2, "R8");
        // R5: zero dwell passes on the first in-progress reply
        run_case(1'b0, 1'b1, 2, 0, 3, 0, 3'b000, 1, 1'b0, 0, "R5 R7");
        // R5: longer dwell counts every tick before passing
        run_case(1'b1, 1'b0, 3, 5, 2, 0, 3'b000, 0, 1'b0, 0, "R5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule